// File: doc/BRIEF.md
# Serial Bit-Clock Source Selector with Baud-Rate Generator

This block derives the transmit and receive bit-clock enables for one channel of a serial controller. Four tick strobes arrive synchronous to the system clock: two external clock pins (pin A and pin B), a processor-clock strobe, and a strobe from an outside clock-recovery loop. An internal 16-bit baud-rate generator divides either pin A or the processor clock. Each direction routes one of pin A, pin B, the generator or the recovered clock through a shared multiplier stage that passes every tick (x1) or one tick in 16, 32 or 64. Each selected bit clock leaves the block as a single-cycle enable pulse.

Software reaches a given baud divisor in one of two ways. Divisors 1, 2 and 4 on pin A come from routing the pin directly with the x16, x32 or x64 multiplier. Pin B allows only these direct divisors. Larger even divisors on pin A, and every even divisor of 4 or more on the processor clock, go through the generator. The block does not check which divisors are legal. It carries out whatever the fields select. Each time the generator count passes through zero, the block raises a status pulse, and an interrupt-enable bit gates that pulse onto an interrupt output.

The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `sclk_route`

## Requirements
- R1: While reset is held, and in the cycles after its release before any tick arrives, `tx_clk_en`, `rx_clk_en`, `gen_zero` and `gen_zero_irq` are all low.
- R2: `mul_sel` (bits 7:6 of its control byte) sets the multiplier for both directions. 00 emits one enable per selected tick, 01 one per 16 ticks, 10 one per 32 and 11 one per 64. Outside x1, two enables on one direction are never in adjacent cycles.
- R3: `tx_route` (bits 4:3 of the routing byte) selects the transmit source. 00 is pin A, 01 is pin B, 10 is the generator output and 11 is the recovered-clock strobe.
- R4: `rx_route` (bits 6:5 of the routing byte) selects the receive source with the same encoding as R3, independently of the transmit selection.
- R5: `gen_en` (bit 0 of the generator byte) enables the generator. While it is low, the generator produces no output edges and no `gen_zero` pulses.
- R6: `gen_use_sys` (bit 1 of the generator byte) feeds the generator from the processor-clock strobe when 1 and from pin A when 0. Pin B never feeds it.
- R7: Let R = {`rld_hi`,`rld_lo`}. After enable, the generator produces a rising output edge on its first input tick and then one rising edge every 2*(R+2) input ticks.
- R8: `gen_zero` pulses for one cycle each time the generator count is at zero when an input tick arrives. That is twice per generator period, and the level of the generator output changes with every pulse.
- R9: `gen_zero_irq` repeats each `gen_zero` pulse when `zero_ie` (bit 1 of the interrupt control byte) is 1. It stays low when `zero_ie` is 0.
- R10: A change of R takes effect only when the count next reloads. The half period already under way completes with the old value.
- R11: A pin or recovered-clock tick in x1 mode gives its enable one cycle after the tick cycle. A routed generator edge in x1 mode gives its enable two cycles after the generator's input tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_tk | input | 1 | Tick strobe from external clock pin A |
| pin_b_tk | input | 1 | Tick strobe from external clock pin B |
| sys_tk | input | 1 | Processor-clock tick strobe |
| rec_tk | input | 1 | Recovered-clock tick strobe |
| mul_sel | input | 2 | Clock multiplier field |
| tx_route | input | 2 | Transmit clock source field |
| rx_route | input | 2 | Receive clock source field |
| gen_en | input | 1 | Generator enable |
| gen_use_sys | input | 1 | Generator input: 1 processor clock, 0 pin A |
| rld_lo | input | 8 | Generator reload value, low byte |
| rld_hi | input | 8 | Generator reload value, high byte |
| zero_ie | input | 1 | Zero-count interrupt enable |
| tx_clk_en | output | 1 | Transmit bit-clock enable pulse |
| rx_clk_en | output | 1 | Receive bit-clock enable pulse |
| gen_zero | output | 1 | Generator zero-count pulse |
| gen_zero_irq | output | 1 | Gated zero-count interrupt pulse |

## Verification
The assertions assume that every tick strobe is already synchronous to `clk` and lasts one cycle per source edge. They also assume that the configuration fields change only between bursts of ticks and not in the cycle a multiplier boundary is crossed. The bench drives each strobe from the falling clock edge with its own fixed cadence and changes fields only in gaps with no ticks. The one exception is the reload value, which is changed on purpose in the middle of a generator half period. Expected pulse counts come from the number of ticks the bench itself issued, divided by the generator period and the multiplier ratio.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic [1:0] {
    SRC_PIN_A = 2'b00,
    SRC_PIN_B = 2'b01,
    SRC_GEN   = 2'b10,
    SRC_REC   = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    MUL_X1  = 2'b00,
    MUL_X16 = 2'b01,
    MUL_X32 = 2'b10,
    MUL_X64 = 2'b11
  } mul_e;

  localparam int MAX_RATIO = 64;
  localparam int PRE_W     = $clog2(MAX_RATIO);

  // last prescaler index before wrap: ratio - 1
  function automatic logic [PRE_W-1:0] last_of(mul_e m);
    if (m == MUL_X1) return '0;
    else             return PRE_W'((1 << (int'(m) + 3)) - 1);
  endfunction

endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/sclk_brg.sv
module sclk_brg #(
  parameter int RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             use_sys_i,
  input  logic             pin_a_tk_i,
  input  logic             sys_tk_i,
  input  logic [RLD_W-1:0] rld_i,
  output logic             rise_o,
  output logic             zero_o
);

  localparam int CNT_W = RLD_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             zero_q, zero_d;
  logic             in_tk;
  logic             at_zero;

  always_comb begin
    in_tk   = use_sys_i ? sys_tk_i : pin_a_tk_i;
    at_zero = (cnt_q == '0);
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    rise_d  = 1'b0;
    zero_d  = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (in_tk) begin
      if (at_zero) begin
        // reload value sampled only here: mid-period writes wait
        cnt_d  = {1'b0, rld_i} + CNT_W'(1);
        lvl_d  = ~lvl_q;
        rise_d = ~lvl_q;
        zero_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      zero_q <= zero_d;
    end
  end

  assign rise_o = rise_q;
  assign zero_o = zero_q;

  // R10
  brg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !in_tk) |=> (cnt_q == $past(cnt_q)));

  // R8
  brg_zero_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> (lvl_q != $past(lvl_q)));

  // R7
  brg_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

endmodule

// File: rtl/sclk_div.sv
module sclk_div
  import sclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mul_e     mul_i,
  input  clk_src_e sel_i,
  input  logic     pin_a_tk_i,
  input  logic     pin_b_tk_i,
  input  logic     gen_tk_i,
  input  logic     rec_tk_i,
  output logic     en_o
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] last;
  logic             en_q, en_d;
  logic             src_tk;

  always_comb begin
    unique case (sel_i)
      SRC_PIN_A: src_tk = pin_a_tk_i;
      SRC_PIN_B: src_tk = pin_b_tk_i;
      SRC_GEN:   src_tk = gen_tk_i;
      default:   src_tk = rec_tk_i;
    endcase
    last  = last_of(mul_i);
    cnt_d = cnt_q;
    en_d  = 1'b0;
    if (src_tk) begin
      if (cnt_q >= last) begin
        cnt_d = '0;
        en_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

  // R2
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mul_i != MUL_X1) |=> !en_q);

endmodule

// File: rtl/sclk_route.sv
module sclk_route
  import sclk_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a_tk,
  input  logic              pin_b_tk,
  input  logic              sys_tk,
  input  logic              rec_tk,
  input  logic [1:0]        mul_sel,
  input  logic [1:0]        tx_route,
  input  logic [1:0]        rx_route,
  input  logic              gen_en,
  input  logic              gen_use_sys,
  input  logic [BYTE_W-1:0] rld_lo,
  input  logic [BYTE_W-1:0] rld_hi,
  input  logic              zero_ie,
  output logic              tx_clk_en,
  output logic              rx_clk_en,
  output logic              gen_zero,
  output logic              gen_zero_irq
);

  localparam int RLD_W = 2 * BYTE_W;
  localparam int N_DIR = 2;

  logic       srst_n;
  logic       gen_rise;
  mul_e       mul_c;
  clk_src_e   route_sel [N_DIR];
  logic [N_DIR-1:0] dir_en;

  sclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sclk_brg #(.RLD_W(RLD_W)) u_brg (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_i       (gen_en),
    .use_sys_i  (gen_use_sys),
    .pin_a_tk_i (pin_a_tk),
    .sys_tk_i   (sys_tk),
    .rld_i      ({rld_hi, rld_lo}),
    .rise_o     (gen_rise),
    .zero_o     (gen_zero)
  );

  assign mul_c        = mul_e'(mul_sel);
  assign route_sel[0] = clk_src_e'(tx_route);
  assign route_sel[1] = clk_src_e'(rx_route);

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    sclk_div u_div (
      .clk        (clk),
      .rst_n      (srst_n),
      .mul_i      (mul_c),
      .sel_i      (route_sel[d]),
      .pin_a_tk_i (pin_a_tk),
      .pin_b_tk_i (pin_b_tk),
      .gen_tk_i   (gen_rise),
      .rec_tk_i   (rec_tk),
      .en_o       (dir_en[d])
    );
  end

  assign tx_clk_en    = dir_en[0];
  assign rx_clk_en    = dir_en[1];
  assign gen_zero_irq = gen_zero & zero_ie;

  // R3
  tx_pin_a_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_clk_en && $past(mul_sel == 2'b00 && tx_route == 2'b00)) |-> $past(pin_a_tk));

  // R4
  rx_rec_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_clk_en && $past(mul_sel == 2'b00 && rx_route == 2'b11)) |-> $past(rec_tk));

  // R6
  gen_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    gen_rise |-> $past(gen_use_sys ? sys_tk : pin_a_tk));

  // R5
  gen_off_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(!gen_en) |-> !gen_zero);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    gen_zero_irq |-> gen_zero);

endmodule

// File: tb/sim_sclk_route.sv
module sim_sclk_route;

  localparam int CLK_P   = 10;
  localparam int RUN_LEN = 240;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_a_tk, pin_b_tk, sys_tk, rec_tk;
  logic [1:0] mul_sel, tx_route, rx_route;
  logic       gen_en, gen_use_sys, zero_ie;
  logic [7:0] rld_lo, rld_hi;
  logic       tx_clk_en, rx_clk_en, gen_zero, gen_zero_irq;

  int errors = 0;
  int checks = 0;
  int n_tx, n_rx, n_zero, n_irq;
  int na, nb, ns, nr;
  logic clr = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  sclk_route u0 (
    .clk(clk), .rst_n(rst_n),
    .pin_a_tk(pin_a_tk), .pin_b_tk(pin_b_tk), .sys_tk(sys_tk), .rec_tk(rec_tk),
    .mul_sel(mul_sel), .tx_route(tx_route), .rx_route(rx_route),
    .gen_en(gen_en), .gen_use_sys(gen_use_sys),
    .rld_lo(rld_lo), .rld_hi(rld_hi), .zero_ie(zero_ie),
    .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
    .gen_zero(gen_zero), .gen_zero_irq(gen_zero_irq)
  );

  always @(negedge clk) begin
    if (clr) begin
      n_tx = 0; n_rx = 0; n_zero = 0; n_irq = 0;
    end else begin
      n_tx   += int'(tx_clk_en);
      n_rx   += int'(rx_clk_en);
      n_zero += int'(gen_zero);
      n_irq  += int'(gen_zero_irq);
    end
  end

  initial begin
    #(CLK_P * 150000);
    $display("FAIL watchdog (all reqs): actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk);
    clr = 1'b1;
    na = 0; nb = 0; ns = 0; nr = 0;
    @(posedge clk);
    #1 clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_a_tk = 0; pin_b_tk = 0; sys_tk = 0; rec_tk = 0;
    gen_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pin_a_tk = (i % 2 == 0);
      pin_b_tk = (i % 3 == 0);
      sys_tk   = 1'b1;
      rec_tk   = (i % 5 == 0);
      na += int'(pin_a_tk); nb += int'(pin_b_tk);
      ns += int'(sys_tk);   nr += int'(rec_tk);
    end
    @(negedge clk);
    pin_a_tk = 0; pin_b_tk = 0; sys_tk = 0; rec_tk = 0;
  endtask

  function automatic int ratio(input int m);
    return (m == 0) ? 1 : (8 << m);
  endfunction

  function automatic int rises(input int t, input int r);
    return (t == 0) ? 0 : (t - 1) / (2 * (r + 2)) + 1;
  endfunction

  function automatic int zeros(input int t, input int r);
    return (t == 0) ? 0 : (t - 1) / (r + 2) + 1;
  endfunction

  function automatic int src_count(input int sel, input int g);
    case (sel)
      0: return na;
      1: return nb;
      2: return g;
      default: return nr;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    pin_a_tk = 0; pin_b_tk = 0; sys_tk = 0; rec_tk = 0;
    mul_sel = 0; tx_route = 0; rx_route = 0;
    gen_en = 0; gen_use_sys = 0; zero_ie = 0; rld_lo = 0; rld_hi = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 held", int'({tx_clk_en, rx_clk_en, gen_zero, gen_zero_irq}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 released", int'({tx_clk_en, rx_clk_en, gen_zero, gen_zero_irq}), 0);

    // R2 R3 R4 R6 R7 R8 R9: sweep of multiplier x transmit source
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        automatic int r  = (m * 4 + s) % 5;
        automatic int us = (m + s) % 2;
        automatic int t, g, z;
        do_reset();
        mul_sel = 2'(m); tx_route = 2'(s); rx_route = 2'(3 - s);
        gen_use_sys = us[0]; zero_ie = s[0];
        {rld_hi, rld_lo} = 16'(r);
        gen_en = 1'b1;
        clear_counts();
        run_ticks(RUN_LEN);
        repeat (6) @(negedge clk);
        t = us ? ns : na;
        g = rises(t, r);
        z = zeros(t, r);
        chk($sformatf("R2 R3 tx m=%0d s=%0d", m, s), n_tx, src_count(s, g) / ratio(m));
        chk($sformatf("R2 R4 rx m=%0d s=%0d", m, s), n_rx, src_count(3 - s, g) / ratio(m));
        chk($sformatf("R6 R7 R8 zero m=%0d s=%0d", m, s), n_zero, z);
        chk($sformatf("R9 irq m=%0d s=%0d", m, s), n_irq, s[0] ? z : 0);
      end
    end

    // R5: generator disabled
    do_reset();
    mul_sel = 0; tx_route = 2'b10; rx_route = 2'b01; gen_use_sys = 1;
    zero_ie = 1; {rld_hi, rld_lo} = 16'd1; gen_en = 1'b0;
    clear_counts();
    run_ticks(50);
    repeat (6) @(negedge clk);
    chk("R5 tx from disabled gen", n_tx, 0);
    chk("R5 zero while disabled", n_zero, 0);
    chk("R4 rx pin B with gen off", n_rx, nb);

    // R10: reload change mid half period
    do_reset();
    mul_sel = 0; tx_route = 2'b10; rx_route = 2'b11; gen_use_sys = 1;
    zero_ie = 1; {rld_hi, rld_lo} = 16'd10; gen_en = 1'b1;
    clear_counts();
    run_ticks(5);
    {rld_hi, rld_lo} = 16'd2;
    run_ticks(20);
    repeat (6) @(negedge clk);
    chk("R10 tx edges", n_tx, 3);
    chk("R10 zero pulses", n_zero, 5);
    chk("R10 R9 irq pulses", n_irq, 5);

    // R11: exact latency
    do_reset();
    mul_sel = 0; tx_route = 2'b00; rx_route = 2'b10; gen_use_sys = 1;
    zero_ie = 0; {rld_hi, rld_lo} = 16'd0; gen_en = 1'b1;
    @(negedge clk);
    pin_a_tk = 1; sys_tk = 1;
    @(negedge clk);
    pin_a_tk = 0; sys_tk = 0;
    chk("R11 tx +1", int'(tx_clk_en), 1);
    chk("R11 rx +1", int'(rx_clk_en), 0);
    chk("R8 zero +1", int'(gen_zero), 1);
    @(negedge clk);
    chk("R11 tx +2", int'(tx_clk_en), 0);
    chk("R11 rx +2", int'(rx_clk_en), 1);
    @(negedge clk);
    chk("R11 rx +3", int'(rx_clk_en), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule